// File: doc/BRIEF.md
# Program/Erase Busy-Phase Status Generator

This block stands in for the busy interval of a small flash-style byte array. A command decoder upstream hands it a start request. Each request carries an operation code, a byte address and a data byte. The block then holds `busy` high for a fixed number of clock cycles, chosen by the operation. When that interval ends it commits the result to the array. A byte program can only clear bits. A sector erase sets one aligned group of bytes to FFh. A chip erase sets every byte to FFh.

Reads are accepted on every cycle and need no handshake. While the array is idle, a read returns the stored byte. While an operation is under way, a read returns a status byte instead, built as follows:

- Bit 7 is a completion flag. It holds the inverse of bit 7 of the byte being programmed, or 0 during an erase.
- Bit 6 flips on each successive status read and always starts at 1 for a new operation.
- Bits 5..0 are 0.

Software polls until bit 7 matches the true value or bit 6 stops flipping.

The start interface uses valid/ready. A request is taken on a clock edge where `start_valid` and `start_ready` are both high. `start_ready` is low for the whole busy interval, so a request held during that time waits or is withdrawn, and has no effect. The read response has no back-pressure: `rd_ack` pulses exactly one cycle after `rd_req`.

Top module: `pe_status_gen`

## Requirements
- R1: After reset every array byte reads FFh, `busy` is low and `start_ready` is high.
- R2: A start request is taken on an edge where `start_valid` and `start_ready` are both high, and `busy` is high in the following cycle.
- R3: `busy` stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES cycles after the accepting edge. The operation code selects the count: code 0 is program, code 1 is sector erase, and codes 2 and 3 (bit 1 set) are chip erase.
- R4: A read request sampled on an edge gives `rd_ack` high and `rd_data` valid in the next cycle, with no back-pressure. When `busy` was low on that edge, `rd_data` is the byte stored at `rd_addr`.
- R5: A status read during a program returns in bit 7 the inverse of bit 7 of the byte being programmed.
- R6: A status read during an erase returns 0 in bit 7, and every status read returns 0 in bits 5..0.
- R7: Bit 6 of status reads is 1 on the first status read of each operation and flips on each later status read of that operation.
- R8: A program stores the bitwise AND of the old byte and the supplied byte.
- R9: A sector erase sets to FFh every byte whose address bits [ADDR_W-1:SECT_W] equal those of the request address, and leaves all other bytes unchanged.
- R10: A chip erase sets every byte to FFh.
- R11: A start request presented while `busy` is high is not taken and leaves the array unchanged.
- R12: Once `busy` has fallen, reads return stable stored data, including the true bit 7 of a programmed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request present |
| start_ready | output | 1 | Start request can be taken (idle) |
| start_op | input | 2 | 0 program, 1 sector erase, 2/3 chip erase |
| start_addr | input | ADDR_W | Byte address (the sector is taken from its upper bits) |
| start_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_ack | output | 1 | Read response valid |
| rd_data | output | 8 | Stored byte, or status byte while busy |

## Verification
The checker assumes `rd_req` is a plain per-cycle strobe. It also assumes that the operation code on an accepted start is stable on the accepting edge, since that code fixes the expected busy length and the meaning of bit 7. The bench changes every input only at falling clock edges. It never has a start accepted in a cycle where a status read is still being answered for an earlier operation. It also withdraws a start held during busy on the same falling edge that shows `busy` low, so the stale request is never taken.

// File: rtl/pesg_pkg.sv
package pesg_pkg;
  typedef enum logic [1:0] {
    KIND_PROG = 2'd0,
    KIND_SECT = 2'd1,
    KIND_CHIP = 2'd2
  } pesg_kind_e;

  function automatic pesg_kind_e pesg_decode(input logic [1:0] code);
    if (code[1])      return KIND_CHIP;
    else if (code[0]) return KIND_SECT;
    else              return KIND_PROG;
  endfunction
endpackage

// File: rtl/pesg_timer.sv
module pesg_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  assign done = busy && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      busy   <= 1'b0;
    end else if (load) begin
      remain <= load_val;
      busy   <= 1'b1;
    end else if (busy) begin
      remain <= remain - CNT_W'(1);
      if (done) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/pesg_array.sv
module pesg_array
  import pesg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  pesg_kind_e        kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  assign rd_byte = cells[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [ADDR_W-1:0] idx;
        idx = ADDR_W'(i);
        unique case (kind)
          KIND_PROG: if (op_addr == idx) cells[i] <= cells[i] & op_data;
          KIND_SECT: if (op_addr[ADDR_W-1:SECT_W] == idx[ADDR_W-1:SECT_W])
                       cells[i] <= 8'hFF;
          default:   cells[i] <= 8'hFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/pesg_status.sv
module pesg_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       busy,
  input  logic       is_prog,
  input  logic       wr_msb,
  input  logic       rd_req,
  input  logic [7:0] arr_byte,
  output logic       rd_ack,
  output logic [7:0] rd_data
);
  logic flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= 8'h00;
      flip    <= 1'b1;
    end else begin
      rd_ack <= rd_req;
      if (accept) flip <= 1'b1;
      if (rd_req) begin
        if (busy) begin
          rd_data <= {(is_prog ? ~wr_msb : 1'b0), flip, 6'b0};
          flip    <= ~flip;
        end else begin
          rd_data <= arr_byte;
        end
      end
    end
  end
endmodule

// File: rtl/pe_status_gen.sv
module pe_status_gen
  import pesg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SECT_W      = 4,
  parameter int unsigned PROG_CYCLES = 12,
  parameter int unsigned SECT_CYCLES = 40,
  parameter int unsigned CHIP_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [1:0]        start_op,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        start_data,
  output logic              busy,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ack,
  output logic [7:0]        rd_data
);
  localparam int unsigned MAX_A = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int unsigned MAX_C = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  logic              accept;
  logic              done;
  logic [CNT_W-1:0]  load_val;
  pesg_kind_e        req_kind;
  pesg_kind_e        cur_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_data;
  logic [7:0]        arr_byte;

  assign start_ready = !busy;
  assign accept      = start_valid && !busy;
  assign req_kind    = pesg_decode(start_op);

  always_comb begin
    unique case (req_kind)
      KIND_PROG: load_val = CNT_W'(PROG_CYCLES);
      KIND_SECT: load_val = CNT_W'(SECT_CYCLES);
      default:   load_val = CNT_W'(CHIP_CYCLES);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_kind <= KIND_PROG;
      cur_addr <= '0;
      cur_data <= 8'h00;
    end else if (accept) begin
      cur_kind <= req_kind;
      cur_addr <= start_addr;
      cur_data <= start_data;
    end
  end

  pesg_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(load_val),
    .busy(busy), .done(done)
  );

  pesg_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) array_i (
    .clk(clk), .rst_n(rst_n), .commit(done), .kind(cur_kind),
    .op_addr(cur_addr), .op_data(cur_data), .rd_addr(rd_addr),
    .rd_byte(arr_byte)
  );

  pesg_status status_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy),
    .is_prog(cur_kind == KIND_PROG), .wr_msb(cur_data[7]),
    .rd_req(rd_req), .arr_byte(arr_byte), .rd_ack(rd_ack), .rd_data(rd_data)
  );
endmodule

// File: rtl/pe_status_gen_chk.sv
module pe_status_gen_chk #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SECT_W      = 4,
  parameter int unsigned PROG_CYCLES = 12,
  parameter int unsigned SECT_CYCLES = 40,
  parameter int unsigned CHIP_CYCLES = 80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic [1:0]        start_op,
  input logic [ADDR_W-1:0] start_addr,
  input logic [7:0]        start_data,
  input logic              busy,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ack,
  input logic [7:0]        rd_data
);
  logic        resp_stat;
  logic        op_erase;
  logic        seen;
  logic        last6;
  int unsigned busy_cnt;
  int unsigned exp_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_stat <= 1'b0;
      op_erase  <= 1'b0;
      seen      <= 1'b0;
      last6     <= 1'b0;
      busy_cnt  <= 0;
      exp_len   <= 0;
    end else begin
      resp_stat <= rd_req && busy;
      if (start_valid && start_ready) begin
        op_erase <= (start_op != 2'd0);
        seen     <= 1'b0;
        busy_cnt <= 0;
        exp_len  <= start_op[1] ? CHIP_CYCLES :
                    (start_op[0] ? SECT_CYCLES : PROG_CYCLES);
      end else begin
        if (busy) busy_cnt <= busy_cnt + 1;
        if (rd_ack && resp_stat) begin
          seen  <= 1'b1;
          last6 <= rd_data[6];
        end
      end
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> busy);
  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == exp_len);
  // R4
  rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_ack);
  // R6
  erase_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && resp_stat |-> (rd_data[5:0] == 6'd0) && !(op_erase && rd_data[7]));
  // R7
  first_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && resp_stat && !seen |-> rd_data[6]);
  // R7
  flip_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && resp_stat && seen |-> rd_data[6] != last6);
endmodule

bind pe_status_gen pe_status_gen_chk #(
  .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYCLES(PROG_CYCLES),
  .SECT_CYCLES(SECT_CYCLES), .CHIP_CYCLES(CHIP_CYCLES)
) chk_i (.*);

// File: tb/pe_status_gen_tb_top.sv
`timescale 1ns/100ps
module pe_status_gen_tb_top;
  localparam int AW = 5;
  localparam int SW = 3;
  localparam int NP = 4;
  localparam int NS = 6;
  localparam int NC = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_valid = 1'b0;
  logic          start_ready;
  logic [1:0]    start_op = 2'd0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    start_data = 8'h00;
  logic          busy;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_ack;
  logic [7:0]    rd_data;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  pe_status_gen #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYCLES(NP),
                  .SECT_CYCLES(NS), .CHIP_CYCLES(NC)) dut_i (.*);

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic rdchk(input int a, input int exp, input string tag);
    rd_req = 1'b1;
    rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    check({tag, " (R4 ack)"}, int'(rd_ack), 1);
    check(tag, int'(rd_data), exp);
  endtask

  task automatic do_start(input int op, input int a, input int d);
    start_valid = 1'b1;
    start_op = 2'(op);
    start_addr = AW'(a);
    start_data = 8'(d);
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  function automatic int op_len(input int op);
    if (op >= 2) return NC;
    if (op == 1) return NS;
    return NP;
  endfunction

  task automatic model_apply(input int op, input int a, input int d);
    for (int i = 0; i < DEPTH; i++) begin
      if (op >= 2) model[i] = 8'hFF;
      else if (op == 1 && (i >> SW) == (a >> SW)) model[i] = 8'hFF;
      else if (op == 0 && i == a) model[i] = model[i] & 8'(d);
    end
  endtask

  // Start an op, read status on every busy cycle, then read the result.
  task automatic run_op(input int op, input int a, input int d);
    logic [7:0] dd;
    dd = 8'(d);
    do_start(op, a, d);
    for (int i = 0; i < op_len(op); i++) begin
      logic b7;
      b7 = (op == 0) ? ~dd[7] : 1'b0;
      // R5 R6 R7 R3
      rdchk((a + i) % DEPTH, {b7, ~i[0], 6'b0}, "R5/R6/R7 status byte");
    end
    model_apply(op, a, d);
    // R12 R3
    rdchk(a, model[a], "R12 stable data after busy");
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < DEPTH; i++) rdchk(i, model[i], tag);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 busy after reset", int'(busy), 0);
    check("R1 start_ready after reset", int'(start_ready), 1);
    sweep("R1 erased after reset");

    // R5 R8: program every byte
    for (int a = 0; a < DEPTH; a++) run_op(0, a, (a * 73 + 29) & 8'hFF);
    sweep("R8 first program pass");
    // R8: second program ANDs with old content
    for (int a = 0; a < DEPTH; a += 2) run_op(0, a, (a * 11) ^ 8'h5A);
    sweep("R8 AND on reprogram");

    // R6 R9: sector erase
    run_op(1, 2 * (1 << SW) + 3, 8'h00);
    sweep("R9 sector erase");

    // R11 R3: start held during busy is ignored
    do_start(1, (1 << SW) + 1, 8'h00);
    start_valid = 1'b1;
    start_op = 2'd0;
    start_addr = AW'(1 << SW);
    start_data = 8'h00;
    begin
      int cnt;
      cnt = 0;
      while (busy && cnt < 100) begin
        check("R11 start_ready low while busy", int'(start_ready), 0);
        cnt++;
        @(negedge clk);
      end
      start_valid = 1'b0;
      check("R3 sector erase busy length", cnt, NS);
    end
    model_apply(1, (1 << SW) + 1, 0);
    rdchk(1 << SW, 8'hFF, "R11 held start ignored");
    sweep("R9 second sector erase");

    // R10 with both chip-erase codes
    run_op(0, 5, 8'h12);
    run_op(3, 7, 8'h00);
    sweep("R10 chip erase code 3");
    run_op(0, 9, 8'hC3);
    run_op(2, 0, 8'h00);
    sweep("R10 chip erase code 2");

    // R2: busy one cycle after acceptance, R3 program length
    start_valid = 1'b1;
    start_op = 2'd0;
    start_addr = AW'(4);
    start_data = 8'h81;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    check("R2 busy after accept", int'(busy), 1);
    begin
      int cnt;
      cnt = 1;
      @(negedge clk);
      while (busy && cnt < 100) begin
        cnt++;
        @(negedge clk);
      end
      check("R3 program busy length", cnt, NP);
    end
    model_apply(0, 4, 8'h81);
    rdchk(4, model[4], "R12 programmed byte");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule